// File: doc/BRIEF.md
# Segment Register Address Extender

This block widens a 32-bit effective address into a 40-bit virtual address. A file of sixteen programmable 12-bit segment identifiers sits inside it. The four most significant bits of the effective address pick one entry. The identifier in that entry takes the place of those four bits. The other 28 address bits pass through unchanged. The resulting space holds 4096 segments of 256 MB each.

Software or a control sequencer loads entries through a single write port, one entry per clock. A lookup request samples the effective address on a clock edge. One cycle later the block presents:
- the 40-bit virtual address,
- the same address split into a 28-bit virtual page number and a 12-bit offset within a 4 KB page, ready for a later translation stage,
- a fault flag that is set when the chosen entry has never been loaded since reset.

Top module: `seg_addr_extender`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears every entry's identifier to 0 and marks it not loaded. After that edge, `rsp_valid` is 0 and `vaddr`, `vpn`, `page_off` and `seg_fault` are all 0.
- R2: A clock edge with `wr_en` high stores `wr_sid` into entry `wr_idx` and marks that entry loaded. A later lookup of that entry returns the stored value.
- R3: A lookup places the selected identifier in `vaddr[39:28]` and copies `eaddr[27:0]` into `vaddr[27:0]`. The selected entry is the one numbered `eaddr[31:28]`.
- R4: `vpn` equals `vaddr[39:12]`, and `page_off` equals `eaddr[11:0]`, for the same response.
- R5: A lookup that selects an entry not loaded since reset sets `seg_fault` to 1. It still drives the address outputs, with identifier field 0.
- R6: A lookup and a write to the same entry can fall on the same edge. In that case the lookup returns the newly written identifier, with `seg_fault` 0.
- R7: A write to a different entry on the same edge as a lookup has no effect on that lookup's result.
- R8: `rsp_valid` is 1 in exactly the cycle after each edge at which `lookup_req` was high, and 0 otherwise.
- R9: In cycles after an edge with `lookup_req` low, `vaddr`, `vpn`, `page_off` and `seg_fault` keep their previous values.
- R10: Writing an entry that is already loaded replaces its identifier. Later lookups return only the new value.
- R11: A lookup of a loaded entry gives `seg_fault` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the segment file |
| wr_idx | input | 4 | Entry to write |
| wr_sid | input | 12 | Identifier to store |
| lookup_req | input | 1 | Lookup request |
| eaddr | input | 32 | Effective address to extend |
| rsp_valid | output | 1 | Response valid, one cycle after a request |
| vaddr | output | 40 | Extended virtual address |
| vpn | output | 28 | Virtual page number |
| page_off | output | 12 | Byte offset within a 4 KB page |
| seg_fault | output | 1 | Selected entry was never loaded |

## Verification
Every lookup result is due exactly one clock after the edge that samples the request. A write becomes visible to a lookup on that same edge through the bypass path. It becomes visible to any later lookup from the following edge.

The bench drives inputs on the falling edge and updates its reference model just after the rising edge. It compares all outputs on the next falling edge, so each comparison lands on the cycle in which the registered result first appears. Because the outputs are also compared on cycles with no request, the bench checks both that `rsp_valid` is low and that the outputs hold their values in those cycles.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int SEG_COUNT  = 16;
    localparam int SID_W      = 12;
    localparam int EA_W       = 32;
    localparam int PAGE_OFF_W = 12;

    localparam int IDX_W      = $clog2(SEG_COUNT);
    localparam int SEG_OFF_W  = EA_W - IDX_W;
    localparam int VA_W       = SID_W + SEG_OFF_W;
    localparam int VPN_W      = VA_W - PAGE_OFF_W;

    typedef logic [IDX_W-1:0]      seg_idx_t;
    typedef logic [SID_W-1:0]      sid_t;
    typedef logic [EA_W-1:0]       eaddr_t;
    typedef logic [SEG_OFF_W-1:0]  seg_off_t;
    typedef logic [VA_W-1:0]       vaddr_t;
    typedef logic [VPN_W-1:0]      vpn_t;
    typedef logic [PAGE_OFF_W-1:0] page_off_t;

    typedef struct packed {
        logic loaded;
        sid_t sid;
    } seg_entry_t;

    typedef struct packed {
        vaddr_t    va;
        vpn_t      vpn;
        page_off_t off;
        logic      fault;
    } xlate_t;

    function automatic seg_idx_t ea_index(input eaddr_t ea);
        return ea[EA_W-1 -: IDX_W];
    endfunction

    function automatic seg_off_t ea_seg_off(input eaddr_t ea);
        return ea[SEG_OFF_W-1:0];
    endfunction

    function automatic vaddr_t join_va(input sid_t sid, input seg_off_t off);
        return {sid, off};
    endfunction

    function automatic vpn_t va_page(input vaddr_t va);
        return va[VA_W-1 -: VPN_W];
    endfunction

    function automatic page_off_t va_offset(input vaddr_t va);
        return va[PAGE_OFF_W-1:0];
    endfunction

endpackage

// File: rtl/seg_id_file.sv
module seg_id_file
    import seg_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en_i,
    input  seg_idx_t   wr_idx_i,
    input  sid_t       wr_sid_i,
    input  seg_idx_t   rd_idx_i,
    output seg_entry_t rd_entry_o
);

    seg_entry_t entries_q [SEG_COUNT];

    generate
        for (genvar g = 0; g < SEG_COUNT; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst) begin
                    entries_q[g] <= '0;
                end else if (wr_en_i && (wr_idx_i == seg_idx_t'(g))) begin
                    entries_q[g] <= '{loaded: 1'b1, sid: wr_sid_i};
                end
            end
        end
    endgenerate

    // Same-edge write to the looked-up entry is forwarded to the reader.
    always_comb begin
        if (wr_en_i && (wr_idx_i == rd_idx_i)) begin
            rd_entry_o = '{loaded: 1'b1, sid: wr_sid_i};
        end else begin
            rd_entry_o = entries_q[rd_idx_i];
        end
    end

    logic     wr_en_d;
    seg_idx_t wr_idx_d;
    sid_t     wr_sid_d;
    always_ff @(posedge clk) begin
        wr_en_d  <= wr_en_i && !rst;
        wr_idx_d <= wr_idx_i;
        wr_sid_d <= wr_sid_i;
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en_d |-> (entries_q[wr_idx_d].loaded && entries_q[wr_idx_d].sid == wr_sid_d))
        else $error("write did not land in entry");

endmodule

// File: rtl/seg_addr_compose.sv
module seg_addr_compose
    import seg_addr_pkg::*;
(
    input  eaddr_t     ea_i,
    input  seg_entry_t entry_i,
    output xlate_t     xl_o
);

    vaddr_t va;

    always_comb begin
        va        = join_va(entry_i.sid, ea_seg_off(ea_i));
        xl_o.va   = va;
        xl_o.vpn  = va_page(va);
        xl_o.off  = va_offset(va);
        xl_o.fault = !entry_i.loaded;
    end

endmodule

// File: rtl/seg_resp_stage.sv
module seg_resp_stage
    import seg_addr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_i,
    input  xlate_t xl_i,
    output logic   rsp_valid_o,
    output xlate_t xl_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            xl_o        <= '0;
        end else begin
            rsp_valid_o <= req_i;
            if (req_i) begin
                xl_o <= xl_i;
            end
        end
    end

    assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (rst)
        req_i |=> rsp_valid_o)
        else $error("missing response after request");

    assert_no_rsp_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !rsp_valid_o)
        else $error("response without request");

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> $stable(xl_o))
        else $error("outputs changed without request");

endmodule

// File: rtl/seg_addr_extender.sv
module seg_addr_extender
    import seg_addr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [SID_W-1:0]      wr_sid,
    input  logic                  lookup_req,
    input  logic [EA_W-1:0]       eaddr,
    output logic                  rsp_valid,
    output logic [VA_W-1:0]       vaddr,
    output logic [VPN_W-1:0]      vpn,
    output logic [PAGE_OFF_W-1:0] page_off,
    output logic                  seg_fault
);

    seg_entry_t sel_entry;
    xlate_t     xl_comb;
    xlate_t     xl_q;

    seg_id_file u_file (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_sid_i   (wr_sid),
        .rd_idx_i   (ea_index(eaddr)),
        .rd_entry_o (sel_entry)
    );

    seg_addr_compose u_compose (
        .ea_i    (eaddr),
        .entry_i (sel_entry),
        .xl_o    (xl_comb)
    );

    seg_resp_stage u_resp (
        .clk         (clk),
        .rst         (rst),
        .req_i       (lookup_req),
        .xl_i        (xl_comb),
        .rsp_valid_o (rsp_valid),
        .xl_o        (xl_q)
    );

    assign vaddr     = xl_q.va;
    assign vpn       = xl_q.vpn;
    assign page_off  = xl_q.off;
    assign seg_fault = xl_q.fault;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !seg_fault && vaddr == '0))
        else $error("outputs not cleared by reset");

    assert_low_bits_pass_R3: assert property (@(posedge clk) disable iff (rst)
        lookup_req |=> (vaddr[SEG_OFF_W-1:0] == $past(eaddr[SEG_OFF_W-1:0])))
        else $error("segment offset bits not carried through");

    assert_offset_split_R4: assert property (@(posedge clk) disable iff (rst)
        lookup_req |=> (page_off == $past(eaddr[PAGE_OFF_W-1:0])))
        else $error("page offset does not match address");

endmodule

// File: tb/seg_addr_extender_test.sv
module seg_addr_extender_test;
    import seg_addr_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                  rst;
    logic                  wr_en;
    logic [IDX_W-1:0]      wr_idx;
    logic [SID_W-1:0]      wr_sid;
    logic                  lookup_req;
    logic [EA_W-1:0]       eaddr;
    logic                  rsp_valid;
    logic [VA_W-1:0]       vaddr;
    logic [VPN_W-1:0]      vpn;
    logic [PAGE_OFF_W-1:0] page_off;
    logic                  seg_fault;

    seg_addr_extender uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sid(wr_sid),
        .lookup_req(lookup_req), .eaddr(eaddr), .rsp_valid(rsp_valid),
        .vaddr(vaddr), .vpn(vpn), .page_off(page_off), .seg_fault(seg_fault)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference model state.
    logic [11:0] m_sid [16];
    bit          m_ok  [16];
    bit          e_rv;
    logic [39:0] e_va;
    bit          e_fault;

    task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "rsp_valid", 64'(rsp_valid), 64'(e_rv));
        chk(tag, "vaddr", 64'(vaddr), 64'(e_va));
        chk({tag, "/R4"}, "vpn", 64'(vpn), 64'(e_va[39:12]));
        chk({tag, "/R4"}, "page_off", 64'(page_off), 64'(e_va[11:0]));
        chk(tag, "seg_fault", 64'(seg_fault), 64'(e_fault));
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_sid[i] = '0;
            m_ok[i]  = 1'b0;
        end
        e_rv = 1'b0; e_va = '0; e_fault = 1'b0;
    endtask

    // Called at a falling edge: drive, pass the rising edge, model, compare at next falling edge.
    task automatic step(input bit req, input logic [31:0] ea, input bit we,
                        input logic [3:0] wi, input logic [11:0] ws, input string tag);
        int idx;
        lookup_req = req; eaddr = ea; wr_en = we; wr_idx = wi; wr_sid = ws;
        @(posedge clk);
        #1;
        e_rv = req;
        if (req) begin
            idx = int'(ea[31:28]);
            if (we && wi == ea[31:28]) begin
                e_va = {ws, ea[27:0]};
                e_fault = 1'b0;
            end else begin
                e_va = {m_sid[idx], ea[27:0]};
                e_fault = !m_ok[idx];
            end
        end
        if (we) begin
            m_sid[int'(wi)] = ws;
            m_ok[int'(wi)]  = 1'b1;
        end
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [11:0] pat(input int i);
        return 12'(12'hA5C ^ (i * 12'd293));
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_idx = '0; wr_sid = '0; lookup_req = 0; eaddr = '0;
        model_reset();
        // R1: requests and writes during reset must leave everything cleared.
        @(negedge clk);
        lookup_req = 1; wr_en = 1; wr_idx = 4'd3; wr_sid = 12'hFFF; eaddr = 32'h3123_4567;
        repeat (3) @(negedge clk);
        compare("R1");
        rst = 1'b0;

        // R1 / R5: every entry unloaded after reset -> fault, identifier 0.
        for (int i = 0; i < 16; i++)
            step(1, {4'(i), 28'h0ABC_DEF ^ 28'(i * 28'h111_1111)}, 0, '0, '0, "R5");

        // R2: load all entries while idle.
        for (int i = 0; i < 16; i++)
            step(0, '0, 1, 4'(i), pat(i), "R2");

        // R3 / R11: lookups of loaded entries with varied low bits.
        for (int i = 15; i >= 0; i--)
            step(1, {4'(i), 28'(32'h0F0F_1234 * (i + 1))}, 0, '0, '0, "R3");
        step(1, 32'h0000_0000, 0, '0, '0, "R11");
        step(1, 32'hFFFF_FFFF, 0, '0, '0, "R11");

        // R9: idle cycles keep the last response; R8: valid drops.
        step(0, 32'h7777_7777, 0, '0, '0, "R9");
        step(0, 32'h1234_5678, 0, '0, '0, "R8");

        // R6: same-edge write and lookup of one entry.
        step(1, 32'h5ABC_0FED, 1, 4'd5, 12'h3C3, "R6");
        step(1, 32'h5000_0001, 0, '0, '0, "R10");

        // R7: write elsewhere on the lookup edge.
        step(1, 32'h9876_5432, 1, 4'd2, 12'h0F1, "R7");
        step(1, 32'h2222_2222, 0, '0, '0, "R2");

        // R10: rewrite an entry and read it back.
        step(0, '0, 1, 4'd9, 12'h001, "R10");
        step(0, '0, 1, 4'd9, 12'hE0E, "R10");
        step(1, 32'h9FFF_F000, 0, '0, '0, "R10");

        // R6 after reset: bypass must also clear the fault on an unloaded entry.
        rst = 1'b1;
        @(negedge clk);
        model_reset();
        compare("R1");
        rst = 1'b0;
        step(1, 32'hC000_0ABC, 1, 4'd12, 12'h7A7, "R6");
        step(1, 32'hD000_0ABC, 0, '0, '0, "R5");
        step(1, 32'hC800_0001, 0, '0, '0, "R2");
        step(0, '0, 0, '0, '0, "R9");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule